// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Datapath

This block is the arithmetic core of a fixed-point signal-processing engine. Two 24-bit buses bring samples and coefficients into a bank of four operand registers, arranged as two pairs. A signed multiplier takes one X register and one Y register. A 56-bit adder/subtractor then writes the result into one of two wide accumulators. Each multiply-accumulate finishes in one clock, and a fresh operand pair can be written in that same clock. The values held before the edge are the ones used by the arithmetic.

Operands are signed fractions in [-1, +1). The raw product is doubled so that its binary point lines up with the accumulator's bit 47. The accumulator's 8 top bits act as headroom, so a chain of products can exceed unity in magnitude without wrapping. A read command converts one accumulator back to a 24-bit word. The conversion path has an optional one-bit scale, round-half-up on the dropped bits, and a saturating limiter. The limiter also raises a sticky limit flag.

Top module: `fx_mac_unit`

## Requirements
- R1: After reset, both accumulators hold zero, `rd_data` is 0, and `rd_vld` and `lim_flag` are low.
- R2: With `ld_en` high, the X bus value goes into X register `ld_sel` and the Y bus value into Y register `ld_sel` at the clock edge. With `ld_en` low, all four operand registers keep their values.
- R3: Command code 1 (multiply) replaces accumulator `acc_sel` (0 = A, 1 = B) with twice the signed product of X register `x_sel` and Y register `y_sel`, sign-extended to 56 bits, in one clock. The unselected accumulator does not change.
- R4: Code 2 adds that doubled product to the selected accumulator, and code 3 subtracts it. Either result is in place after a single clock edge.
- R5: When an operand load and an arithmetic command share a cycle, the command uses the operand values held before that edge. The loaded values take effect from the next command onward.
- R6: Code 0 clears the selected accumulator to zero.
- R7: Accumulated sums up to magnitude 128 are kept exactly. A sum driven past 1.0 and brought back by subtraction reads back as if no excursion had happened.
- R8: Code 4 (read) makes `rd_vld` high for one cycle after the edge, with `rd_data` holding the converted accumulator. The word is accumulator bits 47:24 after scaling, with bit 23 added in for round-half-up. Without a read, `rd_data` holds and `rd_vld` stays low.
- R9: `scale` is sampled with the read command. 0 means no shift, 1 means shift left by one, 2 means arithmetic shift right by one, and 3 behaves as 0.
- R10: If the rounded, scaled value does not fit in 24 signed bits, `rd_data` becomes 0x7FFFFF for positive values or 0x800000 for negative values, and `lim_flag` goes high. It stays high until reset.
- R11: Command codes 5 to 7, and any cycle with `cmd_vld` low, leave the accumulators, `rd_data` and `lim_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| x_bus | input | 24 | X operand bus |
| y_bus | input | 24 | Y operand bus |
| ld_en | input | 1 | Write the bus values into an operand pair |
| ld_sel | input | 1 | Operand pair written by a load |
| cmd_vld | input | 1 | Command strobe |
| cmd_op | input | 3 | Command code: 0 clear, 1 multiply, 2 add-product, 3 subtract-product, 4 read |
| acc_sel | input | 1 | Accumulator target: 0 = A, 1 = B |
| x_sel | input | 1 | X register used by the multiplier |
| y_sel | input | 1 | Y register used by the multiplier |
| scale | input | 2 | Readback shift setting |
| rd_data | output | 24 | Converted accumulator word |
| rd_vld | output | 1 | Read result valid |
| lim_flag | output | 1 | Sticky saturation flag |

## Verification
Some properties are checked on every clock edge: operand registers hold without a load, the accumulator a command does not target is left alone, a clear leaves zero, `rd_data` holds between reads, a rising limit flag comes with a full-scale word, and the flag never drops. The numeric checks need the bench's scenarios. These cover the product scaling, add versus subtract, the same-cycle load ordering, half-up rounding at the tie point, the four scale settings, headroom through an excursion beyond unity, and saturation of both signs including the -1 × -1 case.

// File: rtl/mac_pkg.sv
`timescale 1ns/1ps
package mac_pkg;
  typedef enum logic [2:0] {
    OP_CLR  = 3'd0,
    OP_MPY  = 3'd1,
    OP_MAC  = 3'd2,
    OP_MACN = 3'd3,
    OP_READ = 3'd4
  } mac_op_e;

  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_UP   = 2'd1,
    SC_DOWN = 2'd2,
    SC_ALT  = 2'd3
  } scale_e;
endpackage

// File: rtl/mac_opregs.sv
`timescale 1ns/1ps
module mac_opregs #(
  parameter int DW    = 24,
  parameter int NPAIR = 2,
  localparam int SW   = $clog2(NPAIR)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       ld_en,
  input  logic [SW-1:0]              ld_sel,
  input  logic [DW-1:0]              x_in,
  input  logic [DW-1:0]              y_in,
  output logic [NPAIR-1:0][DW-1:0]   x_q,
  output logic [NPAIR-1:0][DW-1:0]   y_q
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    logic          we;
    logic [DW-1:0] xr, yr;

    always_comb we = ld_en && (ld_sel == SW'(p));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        xr <= '0;
        yr <= '0;
      end else if (we) begin
        xr <= x_in;
        yr <= y_in;
      end
    end

    assign x_q[p] = xr;
    assign y_q[p] = yr;
  end

  // R2: no load strobe, no operand change
  assert_opregs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_en |=> ($stable(x_q) && $stable(y_q)));
endmodule

// File: rtl/mac_core.sv
`timescale 1ns/1ps
module mac_core
  import mac_pkg::*;
#(
  parameter int DW    = 24,
  parameter int GW    = 8,
  parameter int NPAIR = 2,
  localparam int SW   = $clog2(NPAIR),
  localparam int AW   = 2*DW + GW,
  localparam int NACC = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cmd_vld,
  input  logic [2:0]                cmd_op,
  input  logic                      acc_sel,
  input  logic [SW-1:0]             x_sel,
  input  logic [SW-1:0]             y_sel,
  input  logic [NPAIR-1:0][DW-1:0]  x_q,
  input  logic [NPAIR-1:0][DW-1:0]  y_q,
  output logic [NACC-1:0][AW-1:0]   acc_q
);
  logic signed [DW-1:0]   xa, ya;
  logic signed [2*DW-1:0] prod;
  logic [AW-1:0]          pext, cur, upd;
  logic                   wr;

  always_comb begin
    xa   = x_q[x_sel];
    ya   = y_q[y_sel];
    prod = xa * ya;
    pext = {{(GW-1){prod[2*DW-1]}}, prod, 1'b0};
    cur  = acc_q[acc_sel];
    wr   = 1'b0;
    upd  = cur;
    if (cmd_vld) begin
      unique case (cmd_op)
        OP_CLR:  begin upd = '0;          wr = 1'b1; end
        OP_MPY:  begin upd = pext;        wr = 1'b1; end
        OP_MAC:  begin upd = cur + pext;  wr = 1'b1; end
        OP_MACN: begin upd = cur - pext;  wr = 1'b1; end
        default: begin upd = cur;         wr = 1'b0; end
      endcase
    end
  end

  for (genvar i = 0; i < NACC; i++) begin : g_acc
    logic          en;
    logic [AW-1:0] ar;

    always_comb en = wr && (acc_sel == 1'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  ar <= '0;
      else if (en) ar <= upd;
    end

    assign acc_q[i] = ar;

    // R3: a command aimed at the other accumulator leaves this one alone
    assert_other_acc_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_sel != 1'(i)) |=> $stable(acc_q[i]));
    // R6: clear leaves zero
    assert_clr_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld && cmd_op == OP_CLR && acc_sel == 1'(i)) |=> (acc_q[i] == '0));
    // R11: undefined codes do not touch the accumulator
    assert_bad_op_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op > 3'd4) |=> $stable(acc_q[i]));
  end
endmodule

// File: rtl/mac_limiter.sv
`timescale 1ns/1ps
module mac_limiter
  import mac_pkg::*;
#(
  parameter int DW  = 24,
  parameter int GW  = 8,
  localparam int AW = 2*DW + GW,
  localparam int EW = AW + 2
) (
  input  logic [AW-1:0] acc,
  input  logic [1:0]    scale,
  output logic [DW-1:0] word,
  output logic          sat
);
  localparam logic [EW-1:0] HALF = EW'(1) << (DW-1);
  localparam logic [DW-1:0] POS_FS = {1'b0, {(DW-1){1'b1}}};
  localparam logic [DW-1:0] NEG_FS = {1'b1, {(DW-1){1'b0}}};

  logic [EW-1:0]   v, r;
  logic [GW+2:0]   top;
  logic            fits;

  always_comb begin
    unique case (scale)
      SC_UP:   v = {acc[AW-1], acc, 1'b0};
      SC_DOWN: v = {{3{acc[AW-1]}}, acc[AW-1:1]};
      default: v = {{2{acc[AW-1]}}, acc};
    endcase
    r    = v + HALF;
    top  = r[EW-1:2*DW-1];
    fits = (&top) || (~|top);
    sat  = !fits;
    if (fits)          word = r[2*DW-1:DW];
    else if (r[EW-1])  word = NEG_FS;
    else               word = POS_FS;
  end
endmodule

// File: rtl/fx_mac_unit.sv
`timescale 1ns/1ps
module fx_mac_unit
  import mac_pkg::*;
#(
  parameter int DW    = 24,
  parameter int GW    = 8,
  parameter int NPAIR = 2,
  localparam int SW   = $clog2(NPAIR),
  localparam int AW   = 2*DW + GW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] x_bus,
  input  logic [DW-1:0] y_bus,
  input  logic          ld_en,
  input  logic [SW-1:0] ld_sel,
  input  logic          cmd_vld,
  input  logic [2:0]    cmd_op,
  input  logic          acc_sel,
  input  logic [SW-1:0] x_sel,
  input  logic [SW-1:0] y_sel,
  input  logic [1:0]    scale,
  output logic [DW-1:0] rd_data,
  output logic          rd_vld,
  output logic          lim_flag
);
  logic [NPAIR-1:0][DW-1:0] x_q, y_q;
  logic [1:0][AW-1:0]       acc_q;
  logic [DW-1:0]            lim_word;
  logic                     lim_sat;

  logic [DW-1:0] rd_data_d;
  logic          rd_vld_d, lim_flag_d;

  mac_opregs #(.DW(DW), .NPAIR(NPAIR)) i_opregs (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel),
    .x_in(x_bus), .y_in(y_bus), .x_q(x_q), .y_q(y_q)
  );

  mac_core #(.DW(DW), .GW(GW), .NPAIR(NPAIR)) i_core (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .acc_sel(acc_sel), .x_sel(x_sel), .y_sel(y_sel),
    .x_q(x_q), .y_q(y_q), .acc_q(acc_q)
  );

  mac_limiter #(.DW(DW), .GW(GW)) i_limiter (
    .acc(acc_q[acc_sel]), .scale(scale), .word(lim_word), .sat(lim_sat)
  );

  always_comb begin
    rd_vld_d   = cmd_vld && (cmd_op == OP_READ);
    rd_data_d  = rd_vld_d ? lim_word : rd_data;
    lim_flag_d = lim_flag || (rd_vld_d && lim_sat);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_vld   <= 1'b0;
      lim_flag <= 1'b0;
    end else begin
      rd_data  <= rd_data_d;
      rd_vld   <= rd_vld_d;
      lim_flag <= lim_flag_d;
    end
  end

  // R8: without a read command the output word holds and no valid pulse appears
  assert_rd_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_vld && cmd_op == OP_READ) |=> ($stable(rd_data) && !rd_vld));
  // R10: the flag is sticky
  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(lim_flag));
  // R10: a newly raised flag comes with a full-scale word
  assert_sat_word_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lim_flag) |-> (rd_vld && (rd_data == {1'b0, {(DW-1){1'b1}}} ||
                                    rd_data == {1'b1, {(DW-1){1'b0}}})));
endmodule

// File: tb/test_fx_mac_unit.sv
`timescale 1ns/1ps
module test_fx_mac_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [23:0] x_bus, y_bus;
  logic        ld_en, ld_sel, cmd_vld, acc_sel, x_sel, y_sel;
  logic [2:0]  cmd_op;
  logic [1:0]  scale;
  logic [23:0] rd_data;
  logic        rd_vld, lim_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  fx_mac_unit i_fx_mac_unit (
    .clk(clk), .rst_n(rst_n), .x_bus(x_bus), .y_bus(y_bus),
    .ld_en(ld_en), .ld_sel(ld_sel), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .acc_sel(acc_sel), .x_sel(x_sel), .y_sel(y_sel), .scale(scale),
    .rd_data(rd_data), .rd_vld(rd_vld), .lim_flag(lim_flag)
  );

  typedef struct { logic [23:0] d; logic f; string tag; } exp_t;
  exp_t sb[$];

  longint      macc [2];
  logic [23:0] mx [2];
  logic [23:0] my [2];
  bit          mflag;

  function automatic longint wrap56(input longint v);
    logic [63:0] b;
    b = v;
    b = {{8{b[55]}}, b[55:0]};
    return longint'(b);
  endfunction

  function automatic void rd_model(input longint a, input int sc,
                                   output logic [23:0] w, output bit s);
    longint v, q;
    if (sc == 1)      v = a * 2;
    else if (sc == 2) v = a >>> 1;
    else              v = a;
    q = (v + (64'sd1 <<< 23)) >>> 24;
    s = 1'b0;
    if (q > 64'sd8388607)       begin w = 24'h7FFFFF; s = 1'b1; end
    else if (q < -64'sd8388608) begin w = 24'h800000; s = 1'b1; end
    else                        w = q[23:0];
  endfunction

  task automatic step(input bit v, input logic [2:0] op, input bit sel,
                      input bit xs, input bit ys, input bit ld, input bit ls,
                      input logic [23:0] xb, input logic [23:0] yb,
                      input logic [1:0] sc, input string tag);
    longint      p;
    logic [23:0] w;
    bit          s;
    @(negedge clk);
    cmd_vld = v; cmd_op = op; acc_sel = sel; x_sel = xs; y_sel = ys;
    ld_en = ld; ld_sel = ls; x_bus = xb; y_bus = yb; scale = sc;
    if (v) begin
      p = longint'($signed(mx[xs])) * longint'($signed(my[ys])) * 2;
      case (op)
        3'd0: macc[sel] = 0;
        3'd1: macc[sel] = wrap56(p);
        3'd2: macc[sel] = wrap56(macc[sel] + p);
        3'd3: macc[sel] = wrap56(macc[sel] - p);
        3'd4: begin
          rd_model(macc[sel], int'(sc), w, s);
          mflag = mflag | s;
          sb.push_back('{w, mflag, tag});
        end
        default: ;
      endcase
    end
    if (ld) begin mx[ls] = xb; my[ls] = yb; end
  endtask

  task automatic load(input bit ls, input logic [23:0] xb, input logic [23:0] yb);
    step(0, 3'd0, 0, 0, 0, 1, ls, xb, yb, 2'd0, "R2");
  endtask

  task automatic cmd(input logic [2:0] op, input bit sel, input bit xs,
                     input bit ys, input string tag);
    step(1, op, sel, xs, ys, 0, 0, 24'h0, 24'h0, 2'd0, tag);
  endtask

  task automatic rd(input bit sel, input logic [1:0] sc, input string tag);
    step(1, 3'd4, sel, 0, 0, 0, 0, 24'h0, 24'h0, sc, tag);
  endtask

  task automatic idle();
    step(0, 3'd0, 0, 0, 0, 0, 0, 24'h0, 24'h0, 2'd0, "");
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  // monitor: pops the scoreboard as read results appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rd_vld === 1'b1) begin
      checks++;
      if (sb.size() == 0) begin
        fails++;
        $display("FAIL R8: unexpected rd_vld, rd_data=%h exp none", rd_data);
      end else begin
        exp_t e;
        e = sb.pop_front();
        if (rd_data !== e.d || lim_flag !== e.f) begin
          fails++;
          $display("FAIL %s: rd_data=%h flag=%b exp rd_data=%h flag=%b",
                   e.tag, rd_data, lim_flag, e.d, e.f);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, exp completion");
      report();
    end
  end

  initial begin
    rst_n = 1'b0;
    cmd_vld = 0; cmd_op = 0; acc_sel = 0; x_sel = 0; y_sel = 0;
    ld_en = 0; ld_sel = 0; x_bus = 0; y_bus = 0; scale = 0;
    macc[0] = 0; macc[1] = 0; mx[0] = 0; mx[1] = 0; my[0] = 0; my[1] = 0;
    mflag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    checks++;
    if (rd_data !== 24'h0 || rd_vld !== 1'b0 || lim_flag !== 1'b0) begin
      fails++;
      $display("FAIL R1: rd_data=%h rd_vld=%b flag=%b exp 000000 0 0",
               rd_data, rd_vld, lim_flag);
    end
    rd(0, 2'd0, "R1");
    rd(1, 2'd0, "R1");

    // R2/R3: load pair 0, multiply into A, B untouched
    load(0, 24'h400000, 24'h400000);
    cmd(3'd1, 0, 0, 0, "R3");
    rd(0, 2'd0, "R3");
    rd(1, 2'd0, "R3");

    // R4: accumulate and subtract
    load(1, 24'h200000, 24'hC00000);
    cmd(3'd2, 0, 1, 1, "R4");
    rd(0, 2'd0, "R4");
    cmd(3'd3, 1, 0, 1, "R4");
    rd(1, 2'd0, "R4");

    // R5: load in the same cycle as a MAC
    step(1, 3'd2, 0, 0, 0, 1, 0, 24'h100000, 24'h100000, 2'd0, "R5");
    rd(0, 2'd0, "R5");
    cmd(3'd2, 0, 0, 0, "R5");
    rd(0, 2'd0, "R5");

    // R6: clear
    cmd(3'd0, 0, 0, 0, "R6");
    rd(0, 2'd0, "R6");

    // R8: rounding at the tie and just below it
    load(1, 24'h000001, 24'h400000);
    cmd(3'd1, 1, 1, 1, "R8");
    rd(1, 2'd0, "R8");
    load(1, 24'h000001, 24'h3FFFFF);
    cmd(3'd1, 1, 1, 1, "R8");
    rd(1, 2'd0, "R8");
    load(1, 24'hFFFFFF, 24'h400000);
    cmd(3'd1, 1, 1, 1, "R8");
    rd(1, 2'd0, "R8");

    // R9: scale settings
    load(0, 24'h300000, 24'h400000);
    cmd(3'd1, 0, 0, 0, "R9");
    rd(0, 2'd0, "R9");
    rd(0, 2'd1, "R9");
    rd(0, 2'd2, "R9");
    rd(0, 2'd3, "R9");
    load(1, 24'h000003, 24'h400000);
    cmd(3'd1, 1, 1, 1, "R9");
    rd(1, 2'd2, "R9");

    // R11: undefined codes and idle strobes do nothing
    cmd(3'd5, 0, 0, 0, "R11");
    cmd(3'd6, 0, 0, 0, "R11");
    cmd(3'd7, 0, 0, 0, "R11");
    step(0, 3'd0, 0, 0, 0, 0, 0, 24'h0, 24'h0, 2'd0, "R11");
    step(0, 3'd2, 0, 0, 0, 0, 0, 24'h0, 24'h0, 2'd0, "R11");
    rd(0, 2'd0, "R11");

    // R7/R10: headroom beyond unity, saturation, sticky flag
    load(0, 24'h7FFFFF, 24'h7FFFFF);
    cmd(3'd1, 0, 0, 0, "R7");
    for (int k = 0; k < 3; k++) cmd(3'd2, 0, 0, 0, "R7");
    rd(0, 2'd0, "R10");
    for (int k = 0; k < 3; k++) cmd(3'd3, 0, 0, 0, "R7");
    rd(0, 2'd0, "R7");
    load(1, 24'h800000, 24'h800000);
    cmd(3'd1, 1, 1, 1, "R10");
    rd(1, 2'd0, "R10");
    rd(1, 2'd2, "R10");
    load(1, 24'h800000, 24'h7FFFFF);
    cmd(3'd1, 1, 1, 1, "R10");
    cmd(3'd2, 1, 1, 1, "R10");
    cmd(3'd2, 1, 1, 1, "R10");
    rd(1, 2'd0, "R10");
    rd(1, 2'd1, "R10");

    repeat (4) idle();
    // R8: every read produced exactly one result
    checks++;
    if (sb.size() != 0) begin
      fails++;
      $display("FAIL R8: %0d reads without result, exp 0", sb.size());
    end
    done = 1;
    report();
  end
endmodule